// File: doc/BRIEF.md
# Scan-List Acquisition Sequencer

This block paces analog-input conversions from a short, programmable list of channel descriptors. While the block is idle, software appends descriptors one at a time. Each descriptor holds a channel number, a channel kind, a gain code, a polarity bit and a last-in-scan flag. Once armed, a scan-interval timer marks the start of each scan. Inside a scan, a sample-interval timer paces one convert strobe per descriptor. The strobe carries that descriptor's fields to the analog front end.

A scan ends in one of two ways, selected by an input. In list mode it ends at a descriptor with the last flag set, or at the final stored descriptor. In divide mode it ends when a conversion counter expires, and the list wraps as often as needed. A scan counter decides whether the block returns to idle or keeps running. Returning ADC words are reformatted to the polarity of the descriptor that produced them. Words from ghost descriptors are dropped, which lets a list sample some channels less often than others.

Top module: `scanseq_top`

## Requirements
- R1: After reset the block is idle (`busy` low), no convert strobe or output word is issued, and the descriptor list is empty.
- R2: A descriptor word is laid out as bits [11:8] channel, [7:5] kind, [4:2] gain, [1] bipolar, [0] last. While idle, each `cfg_wr` appends one descriptor in write order, and writes are dropped once 16 descriptors are held. Writes and clears presented while `busy` is high have no effect.
- R3: An arm accepted at a clock edge makes `busy` rise, and the first convert strobe appears `scan_first_m1 + samp_first_m1 + 2` clock edges later. Convert strobes occur only while an acquisition is active.
- R4: In list mode a scan converts descriptors from index 0 in order. It ends after a descriptor whose last flag is set, or after the final stored descriptor. Each strobe presents the converted descriptor's channel, kind, gain and polarity. Successive strobes inside a scan are `samp_m1 + 1` cycles apart.
- R5: In divide mode (`end_by_div` high) a scan ends after `div_m1 + 1` conversions. The list wraps to index 0 after each last descriptor, and every scan restarts from index 0.
- R6: A descriptor of kind 7 (ghost) still produces a convert strobe, but its ADC word is never presented on `dout_valid`/`dout`.
- R7: The ADC word returned after a strobe is output one cycle after `adc_valid`. It is passed unchanged for a unipolar descriptor. For a bipolar descriptor its top bit is inverted, which turns offset binary into two's complement.
- R8: Without `continuous`, exactly `scans_m1 + 1` scans run, and then `busy` falls. With `continuous`, scans keep repeating.
- R9: `disarm` returns the block to idle at the next edge, and no convert strobe follows.
- R10: An arm presented while the descriptor list is empty is ignored.
- R11: `cfg_clr` while idle empties the list, so the next descriptor written becomes index 0.
- R12: Scan-interval ticks that fall while a scan is still converting are dropped. The scan timer reloads with `scan_m1` and keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Append one descriptor |
| cfg_entry | input | 12 | Descriptor to append |
| cfg_clr | input | 1 | Empty the descriptor list |
| arm | input | 1 | Start an acquisition |
| disarm | input | 1 | Abort an acquisition |
| continuous | input | 1 | Keep scanning after the scan count is used up |
| end_by_div | input | 1 | End scans by conversion count instead of last flag |
| div_m1 | input | 16 | Conversions per scan minus one |
| scans_m1 | input | 24 | Number of scans minus one |
| scan_first_m1 | input | 16 | First scan interval after arming, minus one |
| scan_m1 | input | 16 | Scan interval minus one |
| samp_first_m1 | input | 16 | First sample interval in a scan, minus one |
| samp_m1 | input | 16 | Sample interval minus one |
| adc_valid | input | 1 | ADC word for the latest strobe is present |
| adc_raw | input | 16 | ADC word, offset binary |
| busy | output | 1 | Acquisition active |
| fe_conv | output | 1 | Convert strobe |
| fe_chan | output | 4 | Channel of the strobed descriptor |
| fe_type | output | 3 | Kind of the strobed descriptor |
| fe_gain | output | 3 | Gain code of the strobed descriptor |
| fe_bip | output | 1 | Polarity of the strobed descriptor |
| dout_valid | output | 1 | Formatted word valid |
| dout | output | 16 | Formatted word |

## Verification
The sequencer is run with a three-descriptor list ended by a last flag, and with a list holding a ghost descriptor. It is also run in divide mode with a conversion count that forces the list to wrap inside a scan, with a scan interval shorter than a scan, and with a full list. These cases separate the two end-of-scan rules and separate a ghost conversion from a skipped one. They also show whether a dropped scan tick disturbs pacing. A continuous run with a mid-run disarm and a locked write checks the stop paths. The ADC words alternate in their top bit, so unipolar and bipolar formatting give visibly different outputs.

// File: rtl/scanseq_pkg.sv
package scanseq_pkg;
    parameter int CHAN_W = 4;
    parameter int GAIN_W = 3;

    typedef enum logic [2:0] {
        KIND_CAL   = 3'd0,
        KIND_DIFF  = 3'd1,
        KIND_NRSE  = 3'd2,
        KIND_RSE   = 3'd3,
        KIND_GHOST = 3'd7
    } kind_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        kind_e             kind;
        logic [GAIN_W-1:0] gain;
        logic              bip;
        logic              last;
    } entry_t;

    localparam int ENTRY_W = $bits(entry_t);

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_SAMP
    } sq_state_e;
endpackage

// File: rtl/scanseq_cfgmem.sv
module scanseq_cfgmem
    import scanseq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             clr,
    input  logic             wr_en,
    input  entry_t           wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output entry_t           rd_data,
    output logic [CNT_W-1:0] cnt
);
    typedef struct packed {
        entry_t [DEPTH-1:0] mem;
        logic [CNT_W-1:0]   cnt;
    } cm_t;

    cm_t cm_d, cm_q;

    always_comb begin
        cm_d = cm_q;
        if (!lock) begin
            if (clr) begin
                cm_d.mem = '0;
                cm_d.cnt = '0;
            end else if (wr_en && cm_q.cnt < CNT_W'(DEPTH)) begin
                cm_d.mem[cm_q.cnt[IDX_W-1:0]] = wr_data;
                cm_d.cnt = cm_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cm_q <= '0;
        else        cm_q <= cm_d;
    end

    assign rd_data = cm_q.mem[rd_idx];
    assign cnt     = cm_q.cnt;
endmodule

// File: rtl/scanseq_dncnt.sv
module scanseq_dncnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)     cnt_d = load_val;
        else if (dec) cnt_d = cnt_q - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/scanseq_fmt.sv
module scanseq_fmt #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv,
    input  logic              conv_bip,
    input  logic              conv_ghost,
    input  logic              adc_valid,
    input  logic [DATA_W-1:0] adc_raw,
    output logic              dout_valid,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic              ghost;
        logic              bip;
        logic              vld;
        logic [DATA_W-1:0] word;
    } fm_t;

    fm_t fm_d, fm_q;

    always_comb begin
        fm_d     = fm_q;
        fm_d.vld = 1'b0;
        // result belongs to the descriptor captured at the previous strobe
        if (adc_valid) begin
            fm_d.vld  = !fm_q.ghost;
            fm_d.word = adc_raw ^ {fm_q.bip, {(DATA_W-1){1'b0}}};
        end
        if (conv) begin
            fm_d.ghost = conv_ghost;
            fm_d.bip   = conv_bip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fm_q <= '0;
        else        fm_q <= fm_d;
    end

    assign dout_valid = fm_q.vld;
    assign dout       = fm_q.word;
endmodule

// File: rtl/scanseq_top.sv
module scanseq_top
    import scanseq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int TMR_W  = 16,
    parameter int DIV_W  = 16,
    parameter int SCN_W  = 24,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [ENTRY_W-1:0] cfg_entry,
    input  logic               cfg_clr,
    input  logic               arm,
    input  logic               disarm,
    input  logic               continuous,
    input  logic               end_by_div,
    input  logic [DIV_W-1:0]   div_m1,
    input  logic [SCN_W-1:0]   scans_m1,
    input  logic [TMR_W-1:0]   scan_first_m1,
    input  logic [TMR_W-1:0]   scan_m1,
    input  logic [TMR_W-1:0]   samp_first_m1,
    input  logic [TMR_W-1:0]   samp_m1,
    input  logic               adc_valid,
    input  logic [DATA_W-1:0]  adc_raw,
    output logic               busy,
    output logic               fe_conv,
    output logic [CHAN_W-1:0]  fe_chan,
    output logic [2:0]         fe_type,
    output logic [GAIN_W-1:0]  fe_gain,
    output logic               fe_bip,
    output logic               dout_valid,
    output logic [DATA_W-1:0]  dout
);
    typedef struct packed {
        sq_state_e        st;
        logic [IDX_W-1:0] idx;
        logic             conv;
        entry_t           ent;
    } sq_t;

    sq_t sq_d, sq_q;

    entry_t           cur;
    logic [CNT_W-1:0] cfg_cnt;
    logic [IDX_W-1:0] seq_idx;
    logic             wrap, scan_end;
    logic             scan_ld, scan_dec, scan_zero;
    logic [TMR_W-1:0] scan_val;
    logic             samp_ld, samp_dec, samp_zero;
    logic [TMR_W-1:0] samp_val;
    logic             div_ld, div_dec, div_zero;
    logic             scn_ld, scn_dec, scn_zero;

    assign busy    = (sq_q.st != SQ_IDLE);
    assign seq_idx = sq_q.idx;

    scanseq_cfgmem #(.DEPTH(DEPTH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (busy),
        .clr     (cfg_clr),
        .wr_en   (cfg_wr),
        .wr_data (entry_t'(cfg_entry)),
        .rd_idx  (sq_q.idx),
        .rd_data (cur),
        .cnt     (cfg_cnt)
    );

    scanseq_dncnt #(.W(TMR_W)) u_scan_tmr (
        .clk(clk), .rst_n(rst_n), .load(scan_ld), .load_val(scan_val),
        .dec(scan_dec), .zero(scan_zero)
    );
    scanseq_dncnt #(.W(TMR_W)) u_samp_tmr (
        .clk(clk), .rst_n(rst_n), .load(samp_ld), .load_val(samp_val),
        .dec(samp_dec), .zero(samp_zero)
    );
    scanseq_dncnt #(.W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_ld), .load_val(div_m1),
        .dec(div_dec), .zero(div_zero)
    );
    scanseq_dncnt #(.W(SCN_W)) u_scn (
        .clk(clk), .rst_n(rst_n), .load(scn_ld), .load_val(scans_m1),
        .dec(scn_dec), .zero(scn_zero)
    );

    assign wrap     = cur.last || (CNT_W'(sq_q.idx) == cfg_cnt - CNT_W'(1));
    assign scan_end = end_by_div ? div_zero : wrap;

    always_comb begin
        sq_d      = sq_q;
        sq_d.conv = 1'b0;
        scan_ld   = 1'b0;
        scan_dec  = 1'b0;
        scan_val  = scan_m1;
        samp_ld   = 1'b0;
        samp_dec  = 1'b0;
        samp_val  = samp_m1;
        div_ld    = 1'b0;
        div_dec   = 1'b0;
        scn_ld    = 1'b0;
        scn_dec   = 1'b0;
        unique case (sq_q.st)
            SQ_IDLE: begin
                if (arm && !disarm && cfg_cnt != '0) begin
                    sq_d.st  = SQ_WAIT;
                    sq_d.idx = '0;
                    scan_ld  = 1'b1;
                    scan_val = scan_first_m1;
                    scn_ld   = 1'b1;
                end
            end
            SQ_WAIT: begin
                if (scan_zero) begin
                    scan_ld  = 1'b1;
                    samp_ld  = 1'b1;
                    samp_val = samp_first_m1;
                    div_ld   = 1'b1;
                    sq_d.idx = '0;
                    sq_d.st  = SQ_SAMP;
                end else begin
                    scan_dec = 1'b1;
                end
            end
            SQ_SAMP: begin
                // scan ticks inside a scan only reload the timer
                if (scan_zero) scan_ld  = 1'b1;
                else           scan_dec = 1'b1;
                if (samp_zero) begin
                    sq_d.conv = 1'b1;
                    sq_d.ent  = cur;
                    div_dec   = 1'b1;
                    if (scan_end) begin
                        sq_d.st = SQ_WAIT;
                        if (!scn_zero)      scn_dec    = 1'b1;
                        else if (continuous) scn_ld    = 1'b1;
                        else                sq_d.st    = SQ_IDLE;
                    end else begin
                        samp_ld  = 1'b1;
                        sq_d.idx = wrap ? '0 : sq_q.idx + IDX_W'(1);
                    end
                end else begin
                    samp_dec = 1'b1;
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase
        if (disarm && sq_q.st != SQ_IDLE) begin
            sq_d.st   = SQ_IDLE;
            sq_d.conv = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign fe_conv = sq_q.conv;
    assign fe_chan = sq_q.ent.chan;
    assign fe_type = sq_q.ent.kind;
    assign fe_gain = sq_q.ent.gain;
    assign fe_bip  = sq_q.ent.bip;

    scanseq_fmt #(.DATA_W(DATA_W)) u_fmt (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv       (sq_q.conv),
        .conv_bip   (sq_q.ent.bip),
        .conv_ghost (sq_q.ent.kind == KIND_GHOST),
        .adc_valid  (adc_valid),
        .adc_raw    (adc_raw),
        .dout_valid (dout_valid),
        .dout       (dout)
    );
endmodule

// File: rtl/scanseq_chk.sv
module scanseq_chk #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             disarm,
    input logic             busy,
    input logic             fe_conv,
    input logic             adc_valid,
    input logic             dout_valid,
    input logic [CNT_W-1:0] cfg_cnt,
    input logic [IDX_W-1:0] seq_idx
);
    AST_CONV_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fe_conv |-> $past(busy)); // R3

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_cnt)); // R2

    AST_CFG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_cnt <= CNT_W'(DEPTH)); // R2

    AST_IDX_IN_LIST: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> CNT_W'(seq_idx) < cfg_cnt); // R4

    AST_DOUT_FROM_ADC: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(adc_valid)); // R6

    AST_DISARM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (!busy && !fe_conv)); // R9

    AST_EMPTY_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !busy && cfg_cnt == '0) |=> !busy); // R10
endmodule

bind scanseq_top scanseq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .disarm     (disarm),
    .busy       (busy),
    .fe_conv    (fe_conv),
    .adc_valid  (adc_valid),
    .dout_valid (dout_valid),
    .cfg_cnt    (cfg_cnt),
    .seq_idx    (seq_idx)
);

// File: tb/tb_scanseq_top.sv
module tb_scanseq_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 0, cfg_clr = 0, arm = 0, disarm = 0;
    logic [11:0] cfg_entry = '0;
    logic        continuous = 0, end_by_div = 0;
    logic [15:0] div_m1 = '0;
    logic [23:0] scans_m1 = '0;
    logic [15:0] scan_first_m1 = '0, scan_m1 = '0, samp_first_m1 = '0, samp_m1 = '0;
    logic        adc_valid;
    logic [15:0] adc_raw;
    logic        busy, fe_conv, fe_bip, dout_valid;
    logic [3:0]  fe_chan;
    logic [2:0]  fe_type, fe_gain;
    logic [15:0] dout;

    always #(CLK_P/2) clk = ~clk;

    scanseq_top dut (.*);

    int checks = 0, errors = 0, cyc = 0;
    int conv_cnt = 0, dout_cnt = 0, first_conv_cyc = 0;
    int chans[$];
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // behavioural reference model
    int          m_state, m_st, m_sp, m_dv, m_sc, m_idx;
    logic        m_conv, m_dvo, m_cg, m_cb;
    logic [11:0] m_ent;
    logic [15:0] m_dout;
    logic [11:0] m_mem[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_st = 0; m_sp = 0; m_dv = 0; m_sc = 0; m_idx = 0;
            m_conv = 0; m_dvo = 0; m_cg = 0; m_cb = 0; m_ent = '0; m_dout = '0;
            m_mem.delete();
        end else begin
            if (adc_valid) begin
                m_dvo  = !m_cg;
                m_dout = adc_raw ^ (m_cb ? 16'h8000 : 16'h0000);
            end else m_dvo = 0;
            if (m_conv) begin
                m_cg = (m_ent[7:5] == 3'd7);
                m_cb = m_ent[1];
            end
            if (m_state == 0) begin
                if (cfg_clr) m_mem.delete();
                else if (cfg_wr && m_mem.size() < 16) m_mem.push_back(cfg_entry);
            end
            m_conv = 0;
            if (disarm) m_state = 0;
            else if (m_state == 0) begin
                if (arm && m_mem.size() > 0) begin
                    m_state = 1; m_st = scan_first_m1; m_sc = scans_m1; m_idx = 0;
                end
            end else if (m_state == 1) begin
                if (m_st == 0) begin
                    m_st = scan_m1; m_sp = samp_first_m1; m_dv = div_m1; m_idx = 0; m_state = 2;
                end else m_st--;
            end else begin
                bit wr, en;
                if (m_st == 0) m_st = scan_m1; else m_st--;
                if (m_sp == 0) begin
                    wr = m_mem[m_idx][0] || (m_idx == m_mem.size() - 1);
                    m_conv = 1; m_ent = m_mem[m_idx];
                    en = end_by_div ? (m_dv == 0) : wr;
                    m_dv = (m_dv == 0) ? 65535 : m_dv - 1;
                    if (en) begin
                        if (m_sc != 0) begin m_sc--; m_state = 1; end
                        else if (continuous) begin m_sc = scans_m1; m_state = 1; end
                        else m_state = 0;
                    end else begin
                        m_sp = samp_m1; m_idx = wr ? 0 : m_idx + 1;
                    end
                end else m_sp--;
            end
        end
    end

    // ADC responder, per-cycle comparison and event log
    initial begin
        logic pend;
        pend = 0; adc_valid = 0; adc_raw = '0;
        forever begin
            @(negedge clk);
            adc_valid = pend;
            adc_raw   = 16'(cyc * 40503 + 17);
            pend      = fe_conv;
            if (rst_n && !done) begin
                chk(busy == (m_state != 0), "R8", "busy", busy, m_state != 0);
                chk(fe_conv == m_conv, "R3", "convert strobe", fe_conv, m_conv);
                if (m_conv)
                    chk({fe_chan, fe_type, fe_gain, fe_bip} == m_ent[11:1], "R4",
                        "strobe fields", {fe_chan, fe_type, fe_gain, fe_bip}, m_ent[11:1]);
                chk(dout_valid == m_dvo, "R6", "dout_valid", dout_valid, m_dvo);
                if (m_dvo) chk(dout == m_dout, "R7", "dout", dout, m_dout);
                if (fe_conv) begin
                    conv_cnt++;
                    chans.push_back(fe_chan);
                    if (conv_cnt == 1) first_conv_cyc = cyc;
                end
                if (dout_valid) dout_cnt++;
            end
        end
    end

    task automatic put(input int ch, input int kind, input int gain, input bit bip, input bit last);
        @(negedge clk);
        cfg_entry = {4'(ch), 3'(kind), 3'(gain), bip, last};
        cfg_wr = 1;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic clear_list();
        @(negedge clk); cfg_clr = 1;
        @(negedge clk); cfg_clr = 0;
    endtask

    int arm_cyc;
    task automatic run_acq();
        conv_cnt = 0; dout_cnt = 0; chans.delete();
        @(negedge clk); arm = 1;
        @(negedge clk); arm = 0; arm_cyc = cyc;
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !fe_conv && !dout_valid, "R1", "idle after reset",
            {busy, fe_conv, dout_valid}, 0);

        // list mode, mixed polarity
        scan_first_m1 = 20; scan_m1 = 40; samp_first_m1 = 2; samp_m1 = 3; scans_m1 = 1;
        put(5, 3, 1, 0, 0); put(4, 3, 2, 1, 0); put(1, 1, 0, 0, 1);
        run_acq();
        chk(conv_cnt == 6, "R4", "converts over two scans", conv_cnt, 6);
        chk(chans.size() == 6 && chans[3] == 5 && chans[5] == 1, "R4", "second scan order",
            chans.size() > 3 ? chans[3] : -1, 5);
        chk(first_conv_cyc - arm_cyc == 22 + 2, "R3", "arm to first strobe",
            first_conv_cyc - arm_cyc, 24);
        chk(dout_cnt == 6, "R7", "words returned", dout_cnt, 6);
        chk(!busy, "R8", "idle after scan count", busy, 0);

        // ghost descriptor
        clear_list();
        scans_m1 = 2;
        put(0, 3, 0, 1, 0); put(1, 7, 0, 0, 1);
        run_acq();
        chk(conv_cnt == 6, "R6", "ghost still converts", conv_cnt, 6);
        chk(dout_cnt == 3, "R6", "ghost words dropped", dout_cnt, 3);
        chk(chans.size() > 0 && chans[0] == 0, "R11", "cleared list restarts at new entry",
            chans.size() > 0 ? chans[0] : -1, 0);

        // divide mode with wrap
        clear_list();
        put(0, 2, 0, 0, 0); put(1, 2, 0, 0, 0); put(2, 2, 0, 0, 1);
        end_by_div = 1; div_m1 = 4; scans_m1 = 1;
        run_acq();
        chk(conv_cnt == 10, "R5", "converts in divide mode", conv_cnt, 10);
        chk(chans.size() == 10 && chans[3] == 0 && chans[4] == 1 && chans[5] == 0, "R5",
            "wrap and restart", chans.size() > 5 ? chans[5] : -1, 0);

        // scan ticks during a scan
        end_by_div = 0; scan_first_m1 = 1; scan_m1 = 2;
        run_acq();
        chk(conv_cnt == 6, "R12", "converts with short scan interval", conv_cnt, 6);

        // continuous, locked write, disarm
        continuous = 1; scans_m1 = 0; scan_m1 = 20;
        conv_cnt = 0;
        @(negedge clk); arm = 1;
        @(negedge clk); arm = 0;
        repeat (150) @(negedge clk);
        put(9, 3, 0, 0, 1);
        repeat (150) @(negedge clk);
        chk(busy, "R8", "continuous still running", busy, 1);
        chk(conv_cnt >= 20, "R8", "continuous converts", conv_cnt, 20);
        disarm = 1;
        @(negedge clk); disarm = 0;
        chk(!busy, "R9", "idle after disarm", busy, 0);
        begin
            int held;
            held = conv_cnt;
            repeat (60) @(negedge clk);
            chk(conv_cnt == held, "R9", "no strobe after disarm", conv_cnt, held);
        end
        continuous = 0;
        run_acq();
        chk(conv_cnt == 3, "R2", "write while busy ignored", conv_cnt, 3);

        // full list
        clear_list();
        scan_m1 = 100;
        for (int i = 0; i < 16; i++) put(i, 3, 0, i[0], 0);
        put(3, 3, 0, 0, 1);
        run_acq();
        chk(conv_cnt == 16, "R2", "full list length", conv_cnt, 16);
        chk(chans.size() == 16 && chans[15] == 15, "R2", "seventeenth write dropped",
            chans.size() == 16 ? chans[15] : -1, 15);

        // empty list
        clear_list();
        @(negedge clk); arm = 1;
        @(negedge clk); arm = 0;
        chk(!busy, "R10", "arm with empty list", busy, 0);
        repeat (5) @(negedge clk);
        chk(!busy && !fe_conv, "R10", "still idle", busy, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule